// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a 32-bit virtual address into a 36-bit physical address by reading a context table and then up to three levels of translation tables through a single memory read/write port. A walk can end at level 1, 2 or 3, so one mapping covers 16 MB, 256 KB or 4 KB. The final mapping entry carries a 3-bit permission field and referenced/modified flags. The walker sets any missing flags in memory before it reports the result, and it grants write permission only when the entry is already marked modified.

A translation request enters on a valid/ready handshake. `req_ready` is high only while the walker is idle. A request presented while the walker is busy is held off and does not change the walk in progress. The walker handles one translation at a time. It raises `busy` from acceptance until a single-cycle `done` pulse, and during that pulse the result ports carry the outcome. The memory port uses a plain request/acknowledge pair. The request and its address stay steady until the acknowledge arrives, and read data is taken in the acknowledge cycle. `xlate_en`, `ctx_base` and `ctx_num` are sampled when a request is accepted.

Every failed translation updates a fault status register and a fault address register. These are visible on the `fsr_q` and `far_q` outputs. `fsr_clr` empties the status register so that the next fault is not flagged as an overflow.

Top module: `ptw_walker`

## Requirements
- R1: When `xlate_en` is low at acceptance, the result is `{4'b0, vaddr}` with read and write permission and fault code 0, and the walker makes no memory access.
- R2: The first memory read of an enabled walk is at `{ctx_base, 4'b0} + ctx_num*4`.
- R3: Bits [1:0] of each fetched entry give its kind: 0 invalid, 1 table pointer, 2 mapping, 3 reserved. A pointer leads to a read at `{entry[31:2], 6'b0}` plus an index. The index is VA[31:24]*4 when leaving the context level, VA[23:18]*4 when leaving level 1, and VA[17:12]*4 when leaving level 2.
- R4: A mapping at level 1, 2 or 3 yields `{entry[31:8], 12'b0}` plus VA[23:0], VA[17:0] or VA[11:0] respectively.
- R5: The fault code puts the level in bits [9:8] and the type in bits [4:2], with all other bits zero. An invalid entry is type 1 and a reserved entry is type 4. Level 0 is the context entry.
- R6: A mapping found at the context level, or a table pointer found at level 3, is a type-4 fault.
- R7: The access index is (write<<2)|(fetch<<1)|supervisor. Permission codes 6 and 7 are supervisor-only, and a user access to them is a type-3 fault. Otherwise each code allows a set of access kinds: 0 read; 1 read/write; 2 read/execute; 3 all; 4 execute; 5 read for user and read/write for supervisor; 6 read/execute; 7 all. A write needs write, a fetch needs execute, and a plain read needs read. A violation is a type-2 fault reported at the mapping's level. A faulting result has no read or write permission.
- R8: The referenced flag is bit 5 and the modified flag is bit 6 of the mapping. If the referenced flag is clear, or the access is a write and the modified flag is clear, the walker writes the entry back with those flags set before `done`. Otherwise it writes nothing.
- R9: Write permission is granted only if the modified flag is set and the code allows writes in the current mode: supervisor codes 1, 3, 5, 7 and user codes 1, 3.
- R10: On a fault, a nonzero status register is first reset to 1 (overflow). It then takes (access index<<5), the fault code and bit 1. The fault address register takes the VA. `fsr_clr` zeroes the status register.
- R11: `req_ready` is high only while idle, `done` lasts one cycle, and `busy` stays high from acceptance to `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | Translation enable, sampled at acceptance |
| ctx_base | input | 32 | Context table base, shifted left 4 to form an address |
| ctx_num | input | CTX_W | Context number |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_super | input | 1 | Access is in supervisor mode |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| res_paddr | output | 36 | Physical address |
| res_rd | output | 1 | Read permitted |
| res_wr | output | 1 | Write permitted |
| res_fault | output | 10 | Fault code, 0 on success |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 36 | Memory byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| fsr_clr | input | 1 | Clear the fault status register |
| fsr_q | output | 32 | Fault status register |
| far_q | output | 32 | Fault address register |

## Verification
The protocol assertions assume that memory raises `mem_ack` only while `mem_req` is high and holds it for a single cycle. They also assume that read data is valid during that cycle. The bench memory model answers on the falling edge, one cycle after it sees a request. It never acknowledges twice in a row, and it keeps the same acknowledge rules for the write-back as for reads. Requests are changed only on falling edges and are withdrawn before the walker returns to idle. This keeps the single-walk-in-flight and steady-request properties within their premises.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 36;
  localparam int ENT_W  = 32;
  localparam int FC_W   = 10;

  localparam logic [1:0] ET_INV  = 2'd0;
  localparam logic [1:0] ET_PTR  = 2'd1;
  localparam logic [1:0] ET_LEAF = 2'd2;

  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;

  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_SHAPE   = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WBACK, S_CHECK, S_FIN} walk_st_t;

  function automatic logic [FC_W-1:0] fcode(logic [1:0] lvl, logic [2:0] ty);
    return {lvl, 3'b000, ty, 2'b00};
  endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic [31:0]      ctx_base,
  input  logic [CTX_W-1:0] ctx_num,
  input  logic [VA_W-1:0]  va,
  input  logic [29:0]      ent_hi,
  input  logic [1:0]       lvl,
  output logic [PA_W-1:0]  root_addr,
  output logic [PA_W-1:0]  next_addr,
  output logic [PA_W-1:0]  leaf_paddr
);
  logic [9:0]      idx;
  logic [PA_W-1:0] off;

  assign root_addr = {ctx_base, 4'b0000} + PA_W'({ctx_num, 2'b00});

  always_comb begin
    case (lvl)
      2'd0:    idx = {va[31:24], 2'b00};
      2'd1:    idx = {2'b00, va[23:18], 2'b00};
      default: idx = {2'b00, va[17:12], 2'b00};
    endcase
  end

  assign next_addr = {ent_hi, 6'b000000} + PA_W'(idx);

  always_comb begin
    case (lvl)
      2'd1:    off = PA_W'(va[23:0]);
      2'd2:    off = PA_W'(va[17:0]);
      default: off = PA_W'(va[11:0]);
    endcase
  end

  assign leaf_paddr = {ent_hi[29:6], 12'h000} + off;
endmodule

// File: rtl/ptw_access_chk.sv
module ptw_access_chk (
  input  logic [2:0] perm,
  input  logic [2:0] acc_idx,
  input  logic       modified,
  output logic [2:0] ftype,
  output logic       wr_ok
);
  logic [7:0] rd_u, wr_u, ex_u, rd_s, wr_s, ex_s, sup_only;

  for (genvar p = 0; p < 8; p++) begin : g_perm
    assign sup_only[p] = (p >= 6);
    assign rd_u[p] = (p <= 3) || (p == 5);
    assign wr_u[p] = (p == 1) || (p == 3);
    assign ex_u[p] = (p >= 2) && (p <= 4);
    assign rd_s[p] = (p != 4);
    assign wr_s[p] = (p % 2 == 1);
    assign ex_s[p] = (p >= 2) && (p != 5);
  end

  logic sup, fch, wrt, can_rd, can_wr, can_ex, ok;

  always_comb begin
    sup    = acc_idx[0];
    fch    = acc_idx[1];
    wrt    = acc_idx[2];
    can_rd = sup ? rd_s[perm] : rd_u[perm];
    can_wr = sup ? wr_s[perm] : wr_u[perm];
    can_ex = sup ? ex_s[perm] : ex_u[perm];
    ok     = (!wrt || can_wr) && (!fch || can_ex) && (wrt || fch || can_rd);
    if (!sup && sup_only[perm]) ftype = 3'd3;
    else if (!ok)               ftype = 3'd2;
    else                        ftype = 3'd0;
    wr_ok = modified && can_wr;
  end
endmodule

// File: rtl/ptw_fault_regs.sv
module ptw_fault_regs
  import ptw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            log_en,
  input  logic            clr,
  input  logic [2:0]      acc_idx,
  input  logic [FC_W-1:0] code,
  input  logic [VA_W-1:0] va,
  output logic [31:0]     fsr_q,
  output logic [31:0]     far_q
);
  logic [31:0] base;
  assign base = clr ? 32'd0 : fsr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
    end else if (log_en) begin
      fsr_q <= ((base != 32'd0) ? 32'd1 : 32'd0) | {22'd0, code}
             | {24'd0, acc_idx, 5'd0} | 32'd2;
      far_q <= va;
    end else if (clr) begin
      fsr_q <= '0;
    end
  end

  // R10
  fsr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_en |=> fsr_q[1]);
  // R10
  fsr_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_en && !clr && fsr_q != 32'd0) |=> fsr_q[0]);
  // R10
  far_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !log_en |=> $stable(far_q));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xlate_en,
  input  logic [31:0]      ctx_base,
  input  logic [CTX_W-1:0] ctx_num,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_vaddr,
  input  logic             req_write,
  input  logic             req_fetch,
  input  logic             req_super,
  output logic             busy,
  output logic             done,
  output logic [35:0]      res_paddr,
  output logic             res_rd,
  output logic             res_wr,
  output logic [9:0]       res_fault,
  output logic             mem_req,
  output logic             mem_we,
  output logic [35:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  input  logic             fsr_clr,
  output logic [31:0]      fsr_q,
  output logic [31:0]      far_q
);
  walk_st_t        st;
  logic [1:0]      lvl_q;
  logic [PA_W-1:0] ptr_q;
  logic [ENT_W-1:0] ent_q;
  logic [VA_W-1:0] va_q;
  logic [2:0]      acc_q;

  logic [PA_W-1:0] root_addr, next_addr, leaf_paddr;
  logic [29:0]     ent_hi;
  logic [2:0]      ftype;
  logic            wr_ok;
  logic            need_wb;
  logic [ENT_W-1:0] upd_ent;

  assign ent_hi = (st == S_READ) ? mem_rdata[31:2] : ent_q[31:2];

  ptw_addr_gen #(.CTX_W(CTX_W)) u_addr (
    .ctx_base(ctx_base), .ctx_num(ctx_num), .va(va_q), .ent_hi(ent_hi),
    .lvl(lvl_q), .root_addr(root_addr), .next_addr(next_addr),
    .leaf_paddr(leaf_paddr)
  );

  ptw_access_chk u_acc (
    .perm(ent_q[4:2]), .acc_idx(acc_q), .modified(ent_q[MOD_BIT]),
    .ftype(ftype), .wr_ok(wr_ok)
  );

  always_comb begin
    need_wb = !mem_rdata[REF_BIT] || (acc_q[2] && !mem_rdata[MOD_BIT]);
    upd_ent = mem_rdata;
    upd_ent[REF_BIT] = 1'b1;
    if (acc_q[2]) upd_ent[MOD_BIT] = 1'b1;
  end

  assign req_ready = (st == S_IDLE);
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign mem_req   = (st == S_READ) || (st == S_WBACK);
  assign mem_we    = (st == S_WBACK);
  assign mem_addr  = ptr_q;
  assign mem_wdata = ent_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lvl_q     <= '0;
      ptr_q     <= '0;
      ent_q     <= '0;
      va_q      <= '0;
      acc_q     <= '0;
      res_paddr <= '0;
      res_rd    <= 1'b0;
      res_wr    <= 1'b0;
      res_fault <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q  <= req_vaddr;
          acc_q <= {req_write, req_fetch, req_super};
          if (xlate_en) begin
            ptr_q <= root_addr;
            lvl_q <= 2'd0;
            st    <= S_READ;
          end else begin
            res_paddr <= {4'b0000, req_vaddr};
            res_rd    <= 1'b1;
            res_wr    <= 1'b1;
            res_fault <= '0;
            st        <= S_FIN;
          end
        end
        S_READ: if (mem_ack) begin
          if (mem_rdata[1:0] == ET_PTR && lvl_q != 2'd3) begin
            ptr_q <= next_addr;
            lvl_q <= lvl_q + 2'd1;
          end else if (mem_rdata[1:0] == ET_LEAF && lvl_q != 2'd0) begin
            ent_q <= upd_ent;
            st    <= need_wb ? S_WBACK : S_CHECK;
          end else begin
            res_fault <= fcode(lvl_q, (mem_rdata[1:0] == ET_INV) ? FT_INVALID : FT_SHAPE);
            res_paddr <= '0;
            res_rd    <= 1'b0;
            res_wr    <= 1'b0;
            st        <= S_FIN;
          end
        end
        S_WBACK: if (mem_ack) st <= S_CHECK;
        S_CHECK: begin
          if (ftype != 3'd0) begin
            res_fault <= fcode(lvl_q, ftype);
            res_paddr <= '0;
            res_rd    <= 1'b0;
            res_wr    <= 1'b0;
          end else begin
            res_fault <= '0;
            res_paddr <= leaf_paddr;
            res_rd    <= 1'b1;
            res_wr    <= wr_ok;
          end
          st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  ptw_fault_regs u_fault (
    .clk(clk), .rst_n(rst_n), .log_en(done && (res_fault != '0)),
    .clr(fsr_clr), .acc_idx(acc_q), .code(res_fault), .va(va_q),
    .fsr_q(fsr_q), .far_q(far_q)
  );

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  // R7
  fault_noperm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault != '0) |-> (!res_rd && !res_wr));
  // R8
  wback_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[REF_BIT]);
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CTXB = 32'h0010_0000;
  localparam logic [35:0] L1B = 36'h0_0200_0000;
  localparam logic [35:0] L2B = 36'h0_0300_0000;
  localparam logic [35:0] L3B = 36'h0_0400_0000;

  logic clk = 0, rst_n = 0;
  logic xlate_en = 0;
  logic [31:0] ctx_base = CTXB;
  logic [7:0]  ctx_num = 8'd5;
  logic req_valid = 0, req_write = 0, req_fetch = 0, req_super = 0;
  logic [31:0] req_vaddr = 0;
  logic req_ready, busy, done, res_rd, res_wr, mem_req, mem_we;
  logic [35:0] res_paddr, mem_addr;
  logic [9:0] res_fault;
  logic [31:0] mem_wdata, fsr_q, far_q;
  logic mem_ack = 0, fsr_clr = 0;
  logic [31:0] mem_rdata = 0;

  int n_chk = 0, n_bad = 0;
  int rd_count = 0, wr_count = 0;
  logic [35:0] first_rd;
  logic first_seen = 0;
  logic [31:0] mem [logic [35:0]];

  logic [35:0] r_pa; logic r_rd, r_wr; logic [9:0] r_fc;

  ptw_walker u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_count++;
        end else begin
          mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'd0;
          if (!first_seen) begin first_rd = mem_addr; first_seen = 1'b1; end
          rd_count++;
        end
      end else mem_ack = 1'b0;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ptd(logic [35:0] base);
    return {base[35:6], 2'b01};
  endfunction
  function automatic logic [31:0] pte(logic [23:0] ppn, logic [2:0] acc, logic r, logic m);
    return {ppn, 1'b0, m, r, acc, 2'b10};
  endfunction
  function automatic logic [35:0] root_a();
    return {CTXB, 4'h0} + 36'(ctx_num) * 4;
  endfunction
  function automatic logic [35:0] l1_a(logic [31:0] va); return L1B + 36'(va[31:24]) * 4; endfunction
  function automatic logic [35:0] l2_a(logic [31:0] va); return L2B + 36'(va[23:18]) * 4; endfunction
  function automatic logic [35:0] l3_a(logic [31:0] va); return L3B + 36'(va[17:12]) * 4; endfunction

  // leaf_lvl 1..3 places ent there; other tables are pointers
  task automatic build(logic [31:0] va, int leaf_lvl, logic [31:0] ent);
    mem.delete();
    mem[root_a()] = ptd(L1B);
    if (leaf_lvl == 1) begin mem[l1_a(va)] = ent; return; end
    mem[l1_a(va)] = ptd(L2B);
    if (leaf_lvl == 2) begin mem[l2_a(va)] = ent; return; end
    mem[l2_a(va)] = ptd(L3B);
    mem[l3_a(va)] = ent;
  endtask

  function automatic logic [2:0] exp_ft(logic [2:0] p, logic w, logic f, logic s);
    logic [2:0] rwx;
    if (!s && p >= 3'd6) return 3'd3;
    case (p)
      3'd0: rwx = 3'b100;  3'd1: rwx = 3'b110;
      3'd2: rwx = 3'b101;  3'd3: rwx = 3'b111;
      3'd4: rwx = 3'b001;  3'd5: rwx = s ? 3'b110 : 3'b100;
      3'd6: rwx = 3'b101;  default: rwx = 3'b111;
    endcase
    if ((w && !rwx[1]) || (f && !rwx[0]) || (!w && !f && !rwx[2])) return 3'd2;
    return 3'd0;
  endfunction

  task automatic run(logic [31:0] va, logic w, logic f, logic s);
    @(negedge clk);
    req_vaddr = va; req_write = w; req_fetch = f; req_super = s; req_valid = 1'b1;
    first_seen = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    while (done !== 1'b1) @(negedge clk);
    r_pa = res_paddr; r_rd = res_rd; r_wr = res_wr; r_fc = res_fault;
    @(negedge clk);
  endtask

  task automatic clear_fsr();
    @(negedge clk); fsr_clr = 1'b1;
    @(negedge clk); fsr_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 ready after reset", req_ready, 1);
    chk("R11 busy after reset", busy, 0);
    chk("R11 done after reset", done, 0);
    chk("R10 fsr after reset", fsr_q, 0);
    chk("R10 far after reset", far_q, 0);
  endtask

  task automatic t_bypass();
    int rc;
    xlate_en = 1'b0; rc = rd_count;
    run(32'h1234_5678, 1'b0, 1'b0, 1'b0);
    chk("R1 paddr", r_pa, 36'h0_1234_5678);
    chk("R1 rd/wr", {r_rd, r_wr}, 2'b11);
    chk("R1 fault", r_fc, 0);
    chk("R1 no memory reads", rd_count - rc, 0);
    xlate_en = 1'b1;
  endtask

  task automatic t_l3_paths();
    logic [31:0] va = 32'h1234_5ABC;
    int rc, wc;
    build(va, 3, pte(24'h0ABCDE, 3'd3, 1'b0, 1'b0));
    rc = rd_count;
    run(va, 1'b0, 1'b0, 1'b1);
    chk("R2 first fetch address", first_rd, root_a());
    chk("R3 four reads", rd_count - rc, 4);
    chk("R4 L3 paddr", r_pa, {24'h0ABCDE, 12'h000} + 36'(va[11:0]));
    chk("R8 referenced set", mem[l3_a(va)], pte(24'h0ABCDE, 3'd3, 1'b1, 1'b0));
    chk("R9 no write before modified", {r_rd, r_wr, r_fc}, {2'b10, 10'd0});
    run(va, 1'b1, 1'b0, 1'b0);
    chk("R8 modified set", mem[l3_a(va)], pte(24'h0ABCDE, 3'd3, 1'b1, 1'b1));
    chk("R9 user write granted", {r_wr, r_fc}, {1'b1, 10'd0});
    wc = wr_count;
    run(va, 1'b0, 1'b0, 1'b0);
    chk("R8 no write-back when flags set", wr_count - wc, 0);
  endtask

  task automatic t_big_pages();
    logic [31:0] va1 = 32'h7F9A_1234, va2 = 32'h5603_FFF0;
    build(va1, 1, pte(24'h001200, 3'd1, 1'b1, 1'b1));
    run(va1, 1'b1, 1'b0, 1'b1);
    chk("R4 L1 16MB paddr", r_pa, {24'h001200, 12'h000} + 36'(va1[23:0]));
    chk("R9 supervisor write granted", r_wr, 1);
    build(va2, 2, pte(24'h003400, 3'd2, 1'b1, 1'b1));
    run(va2, 1'b0, 1'b0, 1'b1);
    chk("R4 L2 256KB paddr", r_pa, {24'h003400, 12'h000} + 36'(va2[17:0]));
    chk("R9 no write on code 2", r_wr, 0);
  endtask

  task automatic t_walk_faults();
    logic [31:0] va = 32'h89AB_CDEF;
    clear_fsr();
    chk("R10 clear", fsr_q, 0);
    build(va, 3, 32'd0);
    mem.delete(l2_a(va));
    run(va, 1'b0, 1'b0, 1'b0);
    chk("R5 invalid at level 2", r_fc, 10'h204);
    chk("R10 fsr first fault", fsr_q, 32'h206);
    chk("R10 far", far_q, va);
    mem.delete(); mem[root_a()] = pte(24'h1, 3'd3, 1'b1, 1'b1);
    run(32'h0000_1000, 1'b0, 1'b1, 1'b1);
    chk("R6 leaf at context level", r_fc, 10'h010);
    chk("R10 overflow", fsr_q, 32'h73);
    chk("R10 far second", far_q, 32'h0000_1000);
    clear_fsr();
    build(va, 3, ptd(L1B));
    run(va, 1'b0, 1'b0, 1'b1);
    chk("R6 pointer at level 3", r_fc, 10'h310);
    build(va, 1, 32'h0000_0003);
    run(va, 1'b0, 1'b0, 1'b1);
    chk("R5 reserved at level 1", r_fc, 10'h110);
  endtask

  task automatic t_perms();
    logic [31:0] va = 32'h0404_2468;
    build(va, 3, pte(24'h000777, 3'd6, 1'b1, 1'b1));
    run(va, 1'b0, 1'b0, 1'b0);
    chk("R7 user on supervisor-only", {r_fc, r_rd, r_wr}, {10'h300 | (10'(exp_ft(3'd6, 0, 0, 0)) << 2), 2'b00});
    build(va, 2, pte(24'h000777, 3'd0, 1'b1, 1'b1));
    run(va, 1'b1, 1'b0, 1'b1);
    chk("R7 write to read-only", r_fc, 10'h200 | (10'(exp_ft(3'd0, 1, 0, 1)) << 2));
    build(va, 3, pte(24'h000777, 3'd4, 1'b1, 1'b1));
    run(va, 1'b0, 1'b1, 1'b0);
    chk("R7 user fetch on execute-only", {r_fc, r_rd, r_wr}, {10'(exp_ft(3'd4, 0, 1, 0)), 2'b10});
  endtask

  task automatic t_busy();
    logic [31:0] va = 32'h1234_5ABC;
    logic held = 1'b1;
    build(va, 3, pte(24'h0ABCDE, 3'd3, 1'b1, 1'b1));
    @(negedge clk);
    req_vaddr = va; req_write = 0; req_fetch = 0; req_super = 1; req_valid = 1;
    @(negedge clk);
    req_vaddr = 32'hFFFF_F000;
    while (done !== 1'b1) begin
      if (req_ready !== 1'b0 || busy !== 1'b1) held = 1'b0;
      @(negedge clk);
    end
    r_pa = res_paddr;
    req_valid = 0;
    @(negedge clk);
    chk("R11 not ready while busy", held, 1);
    chk("R11 second request ignored", r_pa, {24'h0ABCDE, 12'h000} + 36'(va[11:0]));
    chk("R11 done one cycle", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_l3_paths();
    t_big_pages();
    t_walk_faults();
    t_perms();
    t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule